// File: doc/BRIEF.md
# Clip Flag Test Unit

This block keeps the 24-bit clip flag word of a vector coprocessor and carries out the instructions that test, load and read that word. Each cycle it may accept one instruction: an opcode plus the 32-bit instruction word, whose low 24 bits form the immediate operand. The three test instructions reduce the flag and the immediate to a single boolean and write it to integer register 1. The load instruction replaces the flag with the immediate. The read instruction returns the low half of the flag to a destination integer register named by the instruction.

A separate update port stands in for the clipping logic that normally produces the flag. The result leaves the block as a registered 16-bit value together with a write strobe and a register index, one cycle after the instruction, ready for an integer register file outside the block.

Top module: `clip_test_unit`

## Requirements
- R1: After reset the clip flag is zero, `res_we_o` is 0, and `res_o` and `res_idx_o` are zero.
- R2: The immediate is `instr_i[23:0]`. Bits 31:24 of the instruction word never affect any result or the flag.
- R3: AND-test (`op_i` = 1) gives 1 when (flag & immediate) is non-zero, and 0 otherwise.
- R4: EQUAL-test (`op_i` = 2) gives 1 when the 24-bit flag equals the immediate exactly, and 0 otherwise.
- R5: OR-test (`op_i` = 3) gives 1 only when (flag | immediate) has all 24 bits set, and 0 otherwise.
- R6: Every test result is written to integer register 1, zero-extended to 16 bits: in the cycle after the instruction `res_we_o` is 1, `res_idx_o` is 1 and `res_o[15:1]` is 0.
- R7: SET (`op_i` = 4) loads the immediate into the flag, and instructions in later cycles see the new value. SET produces no register write.
- R8: GET (`op_i` = 5) writes flag bits 11:0, zero-extended to 16 bits, to the register given by `dst_idx_i`, one cycle after the instruction.
- R9: A write aimed at integer register 0 is suppressed: `res_we_o` stays 0.
- R10: When `upd_valid_i` is high, the flag takes `upd_flag_i` at the clock edge. A SET in the same cycle takes priority over the update. An instruction in the same cycle as an update or a SET sees the old flag.
- R11: With `op_valid_i` low, or with opcode 0, 6 or 7, nothing is written. When neither SET nor an update occurs, the flag is unchanged.
- R12: When `res_we_o` is 0, `res_o` and `res_idx_o` keep the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 3 | Opcode: 0 none, 1 AND-test, 2 EQUAL-test, 3 OR-test, 4 SET, 5 GET |
| instr_i | input | 32 | Instruction word; bits 23:0 are the immediate |
| dst_idx_i | input | 4 | Destination integer register for GET |
| upd_valid_i | input | 1 | Load the flag from the clipping logic |
| upd_flag_i | input | 24 | Flag value from the clipping logic |
| res_o | output | 16 | Value to write to the integer register |
| res_we_o | output | 1 | Write strobe for the integer register |
| res_idx_o | output | 4 | Integer register index of the write |

## Verification
Random flag and immediate pairs are mixed with pairs built on purpose: the immediate equal to the flag, its exact complement, the complement with one bit cleared, and the disjoint and single-bit overlap cases. These separate the three reductions, since only the exact complement sets the OR-test and only the equal pair sets the EQUAL-test. Garbage in the upper instruction bits shows whether the immediate is cut at bit 24. Directed cycles put SET, the update port and a test in the same cycle to pin the priority and the old-value rule, and aim GET at register 0 to show that the write is suppressed.

// File: rtl/clip_pkg.sv
package clip_pkg;
  typedef enum logic [2:0] {
    CT_NOP = 3'd0,
    CT_AND = 3'd1,
    CT_EQ  = 3'd2,
    CT_OR  = 3'd3,
    CT_SET = 3'd4,
    CT_GET = 3'd5
  } clip_op_e;

  function automatic logic is_test(clip_op_e op);
    return (op == CT_AND) || (op == CT_EQ) || (op == CT_OR);
  endfunction
endpackage

// File: rtl/clip_flag_reg.sv
module clip_flag_reg #(
  parameter int FLAG_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [FLAG_W-1:0] set_val_i,
  input  logic              upd_i,
  input  logic [FLAG_W-1:0] upd_val_i,
  output logic [FLAG_W-1:0] flag_o
);
  logic [FLAG_W-1:0] flag_q, flag_d;

  // instruction load wins over the clipping-logic update
  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = set_val_i;
    else if (upd_i) flag_d = upd_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/clip_eval.sv
module clip_eval
  import clip_pkg::*;
#(
  parameter int FLAG_W       = 24,
  parameter int RES_W        = 16,
  parameter int GET_W        = 12,
  parameter bit OR_VIA_CARRY = 1'b1
) (
  input  clip_op_e          op_i,
  input  logic              valid_i,
  input  logic [FLAG_W-1:0] flag_i,
  input  logic [FLAG_W-1:0] imm_i,
  output logic              we_o,
  output logic              fixed_dst_o,
  output logic [RES_W-1:0]  val_o
);
  localparam int SUM_W = FLAG_W + 1;

  logic              and_hit, eq_hit, or_hit;
  logic [FLAG_W-1:0] or_word;

  assign and_hit = |(flag_i & imm_i);
  assign eq_hit  = (flag_i == imm_i);
  assign or_word = flag_i | imm_i;

  generate
    if (OR_VIA_CARRY) begin : g_or_carry
      // all ones plus one carries into the top bit
      logic [SUM_W-1:0] sum;
      assign sum    = SUM_W'(or_word) + SUM_W'(1);
      assign or_hit = sum[FLAG_W];
    end else begin : g_or_reduce
      assign or_hit = &or_word;
    end
  endgenerate

  always_comb begin
    we_o        = 1'b0;
    fixed_dst_o = 1'b0;
    val_o       = '0;
    if (valid_i) begin
      unique case (op_i)
        CT_AND: begin we_o = 1'b1; fixed_dst_o = 1'b1; val_o = RES_W'(and_hit); end
        CT_EQ:  begin we_o = 1'b1; fixed_dst_o = 1'b1; val_o = RES_W'(eq_hit);  end
        CT_OR:  begin we_o = 1'b1; fixed_dst_o = 1'b1; val_o = RES_W'(or_hit);  end
        CT_GET: begin we_o = 1'b1; val_o = RES_W'(flag_i[GET_W-1:0]); end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clip_wb.sv
module clip_wb #(
  parameter int RES_W     = 16,
  parameter int IDX_W     = 4,
  parameter int FIXED_DST = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             fixed_dst_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [RES_W-1:0] val_i,
  output logic [RES_W-1:0] res_o,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx;
  logic             we_eff;

  assign idx    = fixed_dst_i ? IDX_W'(FIXED_DST) : dst_i;
  // register 0 reads as zero, drop writes to it
  assign we_eff = we_i && (idx != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      idx_o <= '0;
      we_o  <= 1'b0;
    end else begin
      we_o <= we_eff;
      if (we_eff) begin
        res_o <= val_i;
        idx_o <= idx;
      end
    end
  end
endmodule

// File: rtl/clip_test_unit.sv
module clip_test_unit
  import clip_pkg::*;
#(
  parameter int INSTR_W      = 32,
  parameter int FLAG_W       = 24,
  parameter int RES_W        = 16,
  parameter int GET_W        = 12,
  parameter int IDX_W        = 4,
  parameter int FIXED_DST    = 1,
  parameter bit OR_VIA_CARRY = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [2:0]         op_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [IDX_W-1:0]   dst_idx_i,
  input  logic               upd_valid_i,
  input  logic [FLAG_W-1:0]  upd_flag_i,
  output logic [RES_W-1:0]   res_o,
  output logic               res_we_o,
  output logic [IDX_W-1:0]   res_idx_o
);
  clip_op_e          op;
  logic [FLAG_W-1:0] imm;
  logic [FLAG_W-1:0] flag_q;
  logic              set_hit;
  logic              ev_we, ev_fixed;
  logic [RES_W-1:0]  ev_val;

  assign op      = clip_op_e'(op_i);
  assign imm     = instr_i[FLAG_W-1:0];
  assign set_hit = op_valid_i && (op == CT_SET);

  clip_flag_reg #(.FLAG_W(FLAG_W)) u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_hit),
    .set_val_i (imm),
    .upd_i     (upd_valid_i),
    .upd_val_i (upd_flag_i),
    .flag_o    (flag_q)
  );

  clip_eval #(
    .FLAG_W       (FLAG_W),
    .RES_W        (RES_W),
    .GET_W        (GET_W),
    .OR_VIA_CARRY (OR_VIA_CARRY)
  ) u_eval (
    .op_i        (op),
    .valid_i     (op_valid_i),
    .flag_i      (flag_q),
    .imm_i       (imm),
    .we_o        (ev_we),
    .fixed_dst_o (ev_fixed),
    .val_o       (ev_val)
  );

  clip_wb #(
    .RES_W     (RES_W),
    .IDX_W     (IDX_W),
    .FIXED_DST (FIXED_DST)
  ) u_wb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ev_we),
    .fixed_dst_i (ev_fixed),
    .dst_i       (dst_idx_i),
    .val_i       (ev_val),
    .res_o       (res_o),
    .we_o        (res_we_o),
    .idx_o       (res_idx_o)
  );
endmodule

// File: rtl/clip_test_checker.sv
module clip_test_checker #(
  parameter int INSTR_W = 32,
  parameter int FLAG_W  = 24,
  parameter int RES_W   = 16,
  parameter int GET_W   = 12,
  parameter int IDX_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               op_valid_i,
  input logic [2:0]         op_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic [IDX_W-1:0]   dst_idx_i,
  input logic               upd_valid_i,
  input logic [FLAG_W-1:0]  upd_flag_i,
  input logic [RES_W-1:0]   res_o,
  input logic               res_we_o,
  input logic [IDX_W-1:0]   res_idx_o,
  input logic [FLAG_W-1:0]  flag_q
);
  logic test_op, set_op, get_op;
  assign test_op = op_valid_i && (op_i == 3'd1 || op_i == 3'd2 || op_i == 3'd3);
  assign set_op  = op_valid_i && (op_i == 3'd4);
  assign get_op  = op_valid_i && (op_i == 3'd5);

  AST_NO_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> (res_idx_o != '0)); // R9

  AST_TEST_TO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_op |=> (res_we_o && res_idx_o == IDX_W'(1) && res_o[RES_W-1:1] == '0)); // R6

  AST_SET_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_op |=> (flag_q == $past(instr_i[FLAG_W-1:0]))); // R7

  AST_GET_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (get_op && dst_idx_i != '0) |=> (res_we_o && res_o[RES_W-1:GET_W] == '0)); // R8

  AST_UPD_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !set_op) |=> (flag_q == $past(upd_flag_i))); // R10

  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !res_we_o); // R11

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_valid_i && !set_op) |=> $stable(flag_q)); // R11

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_we_o |-> ($stable(res_o) && $stable(res_idx_o))); // R12
endmodule

bind clip_test_unit clip_test_checker #(
  .INSTR_W (INSTR_W),
  .FLAG_W  (FLAG_W),
  .RES_W   (RES_W),
  .GET_W   (GET_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .op_i        (op_i),
  .instr_i     (instr_i),
  .dst_idx_i   (dst_idx_i),
  .upd_valid_i (upd_valid_i),
  .upd_flag_i  (upd_flag_i),
  .res_o       (res_o),
  .res_we_o    (res_we_o),
  .res_idx_o   (res_idx_o),
  .flag_q      (flag_q)
);

// File: tb/tb_clip_test_unit.sv
module tb_clip_test_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] instr_i = '0;
  logic [3:0]  dst_idx_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [23:0] upd_flag_i = '0;
  logic [15:0] res_o;
  logic        res_we_o;
  logic [3:0]  res_idx_o;

  int checks = 0;
  int errors = 0;
  logic [23:0] m_flag = '0;
  logic [15:0] m_res = '0;
  logic [3:0]  m_idx = '0;
  logic        m_we = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  clip_test_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
    .instr_i(instr_i), .dst_idx_i(dst_idx_i), .upd_valid_i(upd_valid_i),
    .upd_flag_i(upd_flag_i), .res_o(res_o), .res_we_o(res_we_o), .res_idx_o(res_idx_o)
  );

  function automatic string tag_of(logic v, logic [2:0] op);
    if (!v) return "R11";
    case (op)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R11";
    endcase
  endfunction

  // expected effect of one cycle on the model
  task automatic model_step(input logic v, input logic [2:0] op, input logic [31:0] ins,
                            input logic [3:0] dst, input logic uv, input logic [23:0] uf);
    logic [23:0] imm = ins[23:0];
    logic        we = 1'b0;
    logic [3:0]  idx = 4'd1;
    logic [15:0] val = '0;
    if (v) begin
      case (op)
        3'd1: begin we = 1'b1; val = 16'((m_flag & imm) != 0); end
        3'd2: begin we = 1'b1; val = 16'(m_flag == imm); end
        3'd3: begin we = 1'b1; val = 16'((m_flag | imm) == 24'hFFFFFF); end
        3'd5: begin we = (dst != 0); idx = dst; val = {4'h0, m_flag[11:0]}; end
        default: we = 1'b0;
      endcase
    end
    m_we = we;
    if (we) begin m_res = val; m_idx = idx; end
    if (v && op == 3'd4) m_flag = imm;
    else if (uv)         m_flag = uf;
  endtask

  task automatic check(input string tag);
    checks++;
    if (res_we_o !== m_we || res_o !== m_res || res_idx_o !== m_idx) begin
      errors++;
      $display("FAIL %s: got we=%0b idx=%0d res=%h, expected we=%0b idx=%0d res=%h",
               tag, res_we_o, res_idx_o, res_o, m_we, m_idx, m_res);
    end
  endtask

  task automatic cyc(input logic v, input logic [2:0] op, input logic [31:0] ins,
                     input logic [3:0] dst, input logic uv, input logic [23:0] uf,
                     input string tag);
    @(negedge clk_i);
    op_valid_i = v; op_i = op; instr_i = ins; dst_idx_i = dst;
    upd_valid_i = uv; upd_flag_i = uf;
    @(posedge clk_i);
    model_step(v, op, ins, dst, uv, uf);
    #1;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c11f));
    repeat (3) @(posedge clk_i);
    #1;
    check("R1"); // reset outputs
    rst_ni = 1'b1;
    cyc(1, 3'd2, 32'h0, 4'd0, 0, 0, "R1");        // flag reads as zero: EQ 0 -> 1
    cyc(1, 3'd5, 32'h0, 4'd3, 0, 0, "R1");        // GET of reset flag
    // R7 SET then GET
    cyc(1, 3'd4, 32'h00ABC123, 4'd0, 0, 0, "R7");
    cyc(1, 3'd5, 32'h0, 4'd7, 0, 0, "R8");
    // R2 garbage in upper bits
    cyc(1, 3'd2, 32'hFFABC123, 4'd0, 0, 0, "R2");
    cyc(1, 3'd4, 32'h5A000F0F, 4'd0, 0, 0, "R2");
    cyc(1, 3'd5, 32'h0, 4'd2, 0, 0, "R2");
    // R3 AND-test: disjoint and single-bit overlap
    cyc(1, 3'd1, 32'h00FFF0F0, 4'd0, 0, 0, "R3");
    cyc(1, 3'd1, 32'h00000100, 4'd0, 0, 0, "R3");
    // R5 OR-test: exact complement and one bit short
    cyc(1, 3'd3, 32'h00FFF0F0, 4'd0, 0, 0, "R5");
    cyc(1, 3'd3, 32'h00FFF070, 4'd0, 0, 0, "R5");
    // R4 EQUAL mismatch in top bit
    cyc(1, 3'd2, 32'h00800F0F, 4'd0, 0, 0, "R4");
    // R9 GET to register 0 suppressed; output holds (R12)
    cyc(1, 3'd5, 32'h0, 4'd0, 0, 0, "R9");
    cyc(0, 3'd1, 32'h00FFFFFF, 4'd0, 0, 0, "R12");
    // R10 update with test in same cycle sees old flag
    cyc(1, 3'd2, 32'h00000F0F, 4'd0, 1, 24'h123456, "R10");
    cyc(1, 3'd2, 32'h00123456, 4'd0, 0, 0, "R10");
    // R10 SET and update together: SET wins
    cyc(1, 3'd4, 32'h00654321, 4'd0, 1, 24'hFFFFFF, "R10");
    cyc(1, 3'd2, 32'h00654321, 4'd0, 0, 0, "R10");
    // R11 reserved opcodes and opcode 0
    cyc(1, 3'd6, 32'h00FFFFFF, 4'd5, 0, 0, "R11");
    cyc(1, 3'd7, 32'h00000000, 4'd5, 0, 0, "R11");
    cyc(1, 3'd0, 32'h00000000, 4'd5, 0, 0, "R11");
    cyc(1, 3'd5, 32'h0, 4'd9, 0, 0, "R11");
    // R6 test result index and width after reset-free run
    cyc(1, 3'd3, 32'h009ABCDE, 4'd4, 0, 0, "R6");

    for (int i = 0; i < N_RANDOM; i++) begin
      logic        v   = ($urandom % 8) != 0;
      logic [2:0]  op  = 3'($urandom % 8);
      logic [31:0] ins = $urandom;
      logic [3:0]  dst = 4'($urandom);
      logic        uv  = ($urandom % 5) == 0;
      logic [23:0] uf  = 24'($urandom);
      int          k   = $urandom % 6;
      if (k == 0) ins[23:0] = m_flag;
      else if (k == 1) ins[23:0] = ~m_flag;
      else if (k == 2) ins[23:0] = ~m_flag & ~(24'h1 << ($urandom % 24));
      else if (k == 3) ins[23:0] = 24'h1 << ($urandom % 24);
      if (($urandom % 10) == 0) dst = 4'd0;
      cyc(v, op, ins, dst, uv, uf, tag_of(v, op));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule